// File: doc/BRIEF.md
# Floppy Drive Select and Motor Control Register Block

This block sits on a narrow byte-wide host I/O bus and holds two registers. The control register carries a two-bit drive address in its low bits and four motor enable bits in its upper nibble. The block turns that register into four active-low motor outputs and four active-low drive select outputs. A drive select goes active only when the addressed drive's motor bit is also set. The second register is a small tape-select store. The host can write it and read it back, but nothing inside the block uses its value.

A static swap input exchanges drives 0 and 1. The exchange covers the select mapping and the motor mapping together, so software can boot from the second physical drive without any change. Drives 2 and 3 are never remapped. The two resets behave differently. An asynchronous active-low hardware reset clears both registers. A synchronous software reset clears only the control register and leaves the tape store alone.

Top module: `fdc_drive_ctl`

## Requirements
- R1: While `rst_hw_n` is low, both registers read as zero and every `ds_n` and `mtr_n` bit is 1 (inactive).
- R2: On a rising clock edge with `cs` and `wr_en` high and `addr` equal to 0x3F2, `wdata` is stored in the control register. A read at that address returns all 8 bits with `rdata_en` = 0xFF.
- R3: With swap off, `mtr_n[i]` equals the inverse of control bit 4+i for i = 0..3.
- R4: Let k be the control value in bits 1:0. The select for drive k is low when motor bit 4+k is set. When that bit is clear, all of `ds_n` is high. At most one `ds_n` bit is ever low.
- R5: When control bits 7:4 are all zero, `ds_n` is 0xF whatever bits 1:0 hold.
- R6: With `swap_sel` high, address 0 uses motor bit 4 and asserts `ds_n[1]`. Address 1 uses motor bit 5 and asserts `ds_n[0]`. `mtr_n[1]` follows inverted bit 4 and `mtr_n[0]` follows inverted bit 5. Drives 2 and 3 map as in R3/R4.
- R7: A write to 0x3F3 stores `wdata[1:0]` as the tape select code: 00 means none, and 01, 10 and 11 mean drives 1, 2 and 3. A read of 0x3F3 returns the code in bits 1:0 with bits 7:2 zero, and `rdata_en` = 0x03 marks bits 7:2 as undriven.
- R8: Writing any value to the tape register changes neither `ds_n` nor `mtr_n`.
- R9: A cycle with `sw_rst` high clears the control register on that edge and takes priority over a write. The tape register keeps its value.
- R10: No register changes when `cs` is low, when `wr_en` is low, or when the address matches neither register. A read with no match, or with `rd_en` or `cs` low, gives `rdata` = 0 and `rdata_en` = 0.
- R11: A change on `swap_sel` takes effect on `ds_n`/`mtr_n` combinationally, with no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_hw_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset, active high |
| cs | input | 1 | Chip select, active high |
| wr_en | input | 1 | Write strobe, active high |
| rd_en | input | 1 | Read strobe, active high |
| addr | input | 10 | I/O address |
| wdata | input | 8 | Write data |
| swap_sel | input | 1 | Exchange drives 0 and 1 |
| rdata | output | 8 | Read data, zero on bits not driven |
| rdata_en | output | 8 | Per-bit drive mask for `rdata` |
| ds_n | output | 4 | Drive selects, active low |
| mtr_n | output | 4 | Motor enables, active low |

## Verification
The hardest case to reach is a swap-mode select where the addressed drive's motor bit is set but the partner drive's bit is clear. Only that case tells a correct exchange of both mappings apart from an exchange of just one. The bench reaches it by writing all 256 control values under each swap setting. The software reset that must spare a tape value is reached by loading a non-zero tape code first and then pulsing `sw_rst` in the same cycle as a control-register write.

// File: rtl/fdc_ctl_pkg.sv
package fdc_ctl_pkg;

   // Which register a read cycle selects
   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_CTRL = 2'd1,
      RSEL_TAPE = 2'd2
   } rsel_e;

endpackage

// File: rtl/fdc_bus_decode.sv
module fdc_bus_decode
   import fdc_ctl_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int CTRL_ADDR = 'h3F2,
   parameter int TAPE_ADDR = 'h3F3
) (
   input  logic              cs,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   output logic              ctrl_we,
   output logic              tape_we,
   output rsel_e             rsel
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] TAPE_A = ADDR_W'(TAPE_ADDR);

   if (CTRL_ADDR == TAPE_ADDR) begin : g_bad_map
      $error("control and tape registers share one address");
   end
   if (CTRL_ADDR >= (1 << ADDR_W) || TAPE_ADDR >= (1 << ADDR_W)) begin : g_bad_width
      $error("register address does not fit ADDR_W");
   end

   logic hit_ctrl;
   logic hit_tape;

   assign hit_ctrl = cs && (addr == CTRL_A);
   assign hit_tape = cs && (addr == TAPE_A);

   assign ctrl_we = hit_ctrl && wr_en;
   assign tape_we = hit_tape && wr_en;

   always_comb begin
      rsel = RSEL_NONE;
      if (rd_en) begin
         if (hit_ctrl)      rsel = RSEL_CTRL;
         else if (hit_tape) rsel = RSEL_TAPE;
      end
   end

endmodule

// File: rtl/fdc_reg_bank.sv
module fdc_reg_bank #(
   parameter int DATA_W = 8,
   parameter int TAPE_W = 2
) (
   input  logic              clk,
   input  logic              rst_hw_n,
   input  logic              sw_rst,
   input  logic              ctrl_we,
   input  logic              tape_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [TAPE_W-1:0] tape_q
);

   if (TAPE_W > DATA_W || TAPE_W < 1) begin : g_bad_tape
      $error("TAPE_W must be between 1 and DATA_W");
   end

   // Control register: both resets clear it, software reset wins over a write
   always_ff @(posedge clk or negedge rst_hw_n) begin
      if (!rst_hw_n)    ctrl_q <= '0;
      else if (sw_rst)  ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= wdata;
   end

   // Tape store: only the hardware reset clears it
   always_ff @(posedge clk or negedge rst_hw_n) begin
      if (!rst_hw_n)    tape_q <= '0;
      else if (tape_we) tape_q <= wdata[TAPE_W-1:0];
   end

   assert_sw_clear_R9: assert property (@(posedge clk) disable iff (!rst_hw_n)
      sw_rst |=> (ctrl_q == '0));

   assert_tape_keep_R9: assert property (@(posedge clk) disable iff (!rst_hw_n)
      (sw_rst && !tape_we) |=> $stable(tape_q));

   assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_hw_n)
      (!ctrl_we && !sw_rst) |=> $stable(ctrl_q));

endmodule

// File: rtl/fdc_drive_map.sv
module fdc_drive_map #(
   parameter int NUM_DRV = 4,
   parameter int SEL_W   = 2
) (
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [NUM_DRV-1:0] motor_i,
   input  logic               swap_sel,
   output logic [NUM_DRV-1:0] ds_n,
   output logic [NUM_DRV-1:0] mtr_n
);

   if (NUM_DRV < 2 || (1 << SEL_W) < NUM_DRV) begin : g_bad_cfg
      $error("drive count needs at least 2 drives and a wide enough select");
   end

   // hit[l]: logical drive l is addressed and its motor bit is set
   logic [NUM_DRV-1:0] hit;

   for (genvar l = 0; l < NUM_DRV; l++) begin : g_logical
      assign hit[l] = (sel_i == SEL_W'(l)) && motor_i[l];
   end

   for (genvar p = 0; p < NUM_DRV; p++) begin : g_phys
      if (p < 2) begin : g_pair
         localparam int PEER = p ^ 1;
         assign ds_n[p]  = swap_sel ? ~hit[PEER]     : ~hit[p];
         assign mtr_n[p] = swap_sel ? ~motor_i[PEER] : ~motor_i[p];
      end else begin : g_fixed
         assign ds_n[p]  = ~hit[p];
         assign mtr_n[p] = ~motor_i[p];
      end
   end

endmodule

// File: rtl/fdc_drive_ctl.sv
module fdc_drive_ctl
   import fdc_ctl_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int DATA_W    = 8,
   parameter int NUM_DRV   = 4,
   parameter int TAPE_W    = 2,
   parameter int MOTOR_LSB = 4,
   parameter int CTRL_ADDR = 'h3F2,
   parameter int TAPE_ADDR = 'h3F3
) (
   input  logic              clk,
   input  logic              rst_hw_n,
   input  logic              sw_rst,
   input  logic              cs,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              swap_sel,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] rdata_en,
   output logic [NUM_DRV-1:0] ds_n,
   output logic [NUM_DRV-1:0] mtr_n
);

   localparam int SEL_W = $clog2(NUM_DRV);

   if (MOTOR_LSB + NUM_DRV > DATA_W || MOTOR_LSB < SEL_W) begin : g_bad_layout
      $error("motor field overlaps select field or exceeds DATA_W");
   end

   logic              ctrl_we;
   logic              tape_we;
   rsel_e             rsel;
   logic [DATA_W-1:0] ctrl_q;
   logic [TAPE_W-1:0] tape_q;

   fdc_bus_decode #(
      .ADDR_W    (ADDR_W),
      .CTRL_ADDR (CTRL_ADDR),
      .TAPE_ADDR (TAPE_ADDR)
   ) u_dec (
      .cs      (cs),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .ctrl_we (ctrl_we),
      .tape_we (tape_we),
      .rsel    (rsel)
   );

   fdc_reg_bank #(
      .DATA_W (DATA_W),
      .TAPE_W (TAPE_W)
   ) u_regs (
      .clk      (clk),
      .rst_hw_n (rst_hw_n),
      .sw_rst   (sw_rst),
      .ctrl_we  (ctrl_we),
      .tape_we  (tape_we),
      .wdata    (wdata),
      .ctrl_q   (ctrl_q),
      .tape_q   (tape_q)
   );

   fdc_drive_map #(
      .NUM_DRV (NUM_DRV),
      .SEL_W   (SEL_W)
   ) u_map (
      .sel_i    (ctrl_q[SEL_W-1:0]),
      .motor_i  (ctrl_q[MOTOR_LSB +: NUM_DRV]),
      .swap_sel (swap_sel),
      .ds_n     (ds_n),
      .mtr_n    (mtr_n)
   );

   // Read mux: tape reads drive only the tape field, the rest is marked undriven
   always_comb begin
      rdata    = '0;
      rdata_en = '0;
      case (rsel)
         RSEL_CTRL: begin
            rdata    = ctrl_q;
            rdata_en = '1;
         end
         RSEL_TAPE: begin
            rdata[TAPE_W-1:0]    = tape_q;
            rdata_en[TAPE_W-1:0] = '1;
         end
         default: ;
      endcase
   end

   assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_hw_n)
      $countones(~ds_n) <= 1);

   assert_idle_select_R5: assert property (@(posedge clk) disable iff (!rst_hw_n)
      (ctrl_q[MOTOR_LSB +: NUM_DRV] == '0) |-> (ds_n == '1));

   assert_tape_write_R7: assert property (@(posedge clk) disable iff (!rst_hw_n)
      tape_we |=> (tape_q == $past(wdata[TAPE_W-1:0])));

endmodule

// File: tb/sim_fdc_drive_ctl.sv
module sim_fdc_drive_ctl;

   localparam logic [9:0] A_CTRL = 10'h3F2;
   localparam logic [9:0] A_TAPE = 10'h3F3;

   logic       clk = 1'b0;
   logic       rst_hw_n = 1'b0;
   logic       sw_rst = 1'b0;
   logic       cs = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [9:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       swap_sel = 1'b0;
   logic [7:0] rdata;
   logic [7:0] rdata_en;
   logic [3:0] ds_n;
   logic [3:0] mtr_n;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   fdc_drive_ctl u0 (
      .clk      (clk),
      .rst_hw_n (rst_hw_n),
      .sw_rst   (sw_rst),
      .cs       (cs),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wdata    (wdata),
      .swap_sel (swap_sel),
      .rdata    (rdata),
      .rdata_en (rdata_en),
      .ds_n     (ds_n),
      .mtr_n    (mtr_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive inputs at a falling edge, capture on the next rising edge
   task automatic bus_wr(input logic [9:0] a, input logic [7:0] d,
                         input logic c = 1'b1, input logic w = 1'b1);
      @(negedge clk);
      cs = c; wr_en = w; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [9:0] a, output logic [7:0] d, output logic [7:0] en);
      @(negedge clk);
      cs = 1'b1; rd_en = 1'b1; addr = a;
      #1;
      d = rdata; en = rdata_en;
      cs = 1'b0; rd_en = 1'b0;
   endtask

   function automatic logic [3:0] exp_ds(input logic [7:0] v, input logic sw);
      int sel = int'(v[1:0]);
      int tgt = (sw && sel < 2) ? (sel ^ 1) : sel;
      if (!v[4 + sel]) return 4'hF;
      return ~(4'b0001 << tgt);
   endfunction

   function automatic logic [3:0] exp_mtr(input logic [7:0] v, input logic sw);
      logic [3:0] b = v[7:4];
      if (sw) b = {b[3], b[2], b[0], b[1]};
      return ~b;
   endfunction

   initial begin
      logic [7:0] d, en;

      // R1: reset state
      #5;
      chk("R1 ds_n in reset", ds_n, 4'hF);
      chk("R1 mtr_n in reset", mtr_n, 4'hF);
      repeat (3) @(negedge clk);
      rst_hw_n = 1'b1;
      bus_rd(A_CTRL, d, en);
      chk("R1 ctrl after reset", d, 8'h00);
      bus_rd(A_TAPE, d, en);
      chk("R1 tape after reset", d, 8'h00);

      // Sweep every control value under both swap settings
      for (int s = 0; s < 2; s++) begin
         for (int v = 0; v < 256; v++) begin
            logic [7:0] vb = 8'(v);
            swap_sel = s[0];
            bus_wr(A_CTRL, vb);
            chk(s ? "R6 swapped motor" : "R3 motor map", mtr_n, exp_mtr(vb, s[0]));
            chk(s ? "R6 swapped select" : (vb[7:4] == 0 ? "R5 idle select" : "R4 select"),
                ds_n, exp_ds(vb, s[0]));
            if (v % 17 == 0) begin
               bus_rd(A_CTRL, d, en);
               chk("R2 readback", d, vb);
               chk("R2 read mask", en, 8'hFF);
            end
         end
      end

      // R11: swap acts without a write (address 0, motor bit 4 only)
      swap_sel = 1'b0;
      bus_wr(A_CTRL, 8'h10);
      chk("R11 pre-swap ds", ds_n, 4'hE);
      @(negedge clk); swap_sel = 1'b1; #1;
      chk("R11 swap ds", ds_n, 4'hD);
      chk("R11 swap mtr", mtr_n, 4'hD);
      @(negedge clk); swap_sel = 1'b0; #1;
      chk("R11 unswap ds", ds_n, 4'hE);

      // R7 / R8: tape codes, stored but isolated from the drive outputs
      bus_wr(A_CTRL, 8'hA6);
      for (int t = 0; t < 4; t++) begin
         bus_wr(A_TAPE, 8'hFC | 8'(t));
         chk("R8 ds unaffected", ds_n, exp_ds(8'hA6, 1'b0));
         chk("R8 mtr unaffected", mtr_n, exp_mtr(8'hA6, 1'b0));
         bus_rd(A_TAPE, d, en);
         chk("R7 tape code", d, 8'(t));
         chk("R7 tape mask", en, 8'h03);
      end

      // R10: ignored writes and unmatched reads
      bus_wr(A_CTRL, 8'h55, 1'b0, 1'b1);
      bus_wr(A_CTRL, 8'h55, 1'b1, 1'b0);
      bus_wr(10'h3F0, 8'h55);
      bus_wr(A_TAPE, 8'h01, 1'b0, 1'b1);
      bus_rd(A_CTRL, d, en);
      chk("R10 ctrl kept", d, 8'hA6);
      bus_rd(A_TAPE, d, en);
      chk("R10 tape kept", d, 8'h03);
      bus_rd(10'h3F0, d, en);
      chk("R10 unmatched data", d, 8'h00);
      chk("R10 unmatched mask", en, 8'h00);
      @(negedge clk); cs = 1'b1; addr = A_CTRL; #1;
      chk("R10 no rd_en", rdata_en, 8'h00);
      cs = 1'b0;

      // R9: software reset with a simultaneous control write
      @(negedge clk);
      sw_rst = 1'b1; cs = 1'b1; wr_en = 1'b1; addr = A_CTRL; wdata = 8'hF3;
      @(negedge clk);
      sw_rst = 1'b0; cs = 1'b0; wr_en = 1'b0;
      chk("R9 ctrl cleared ds", ds_n, 4'hF);
      chk("R9 ctrl cleared mtr", mtr_n, 4'hF);
      bus_rd(A_CTRL, d, en);
      chk("R9 ctrl zero", d, 8'h00);
      bus_rd(A_TAPE, d, en);
      chk("R9 tape kept", d, 8'h03);

      // R1: hardware reset mid-run clears the tape store too
      bus_wr(A_CTRL, 8'h83);
      @(negedge clk); rst_hw_n = 1'b0; #1;
      chk("R1 hw reset ds", ds_n, 4'hF);
      chk("R1 hw reset mtr", mtr_n, 4'hF);
      @(negedge clk); rst_hw_n = 1'b1;
      bus_rd(A_TAPE, d, en);
      chk("R1 hw reset tape", d, 8'h00);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule